// File: doc/BRIEF.md
# B-Channel Transmit Buffer with Transparent Bypass

This block buffers outgoing bytes for one B-channel. A host pushes bytes through a valid/ready write stream into a circular byte store. A 13-bit write pointer and a 13-bit read pointer track the store. Two 5-bit frame counters separate completed frames from frames that have already been sent. A line-side slot strobe asks for one byte per 8-bit slot. The block returns that byte as a parallel value and also shifts it out serially, one bit per bit-clock enable.

In framed mode a byte leaves only when at least one whole frame is waiting. Otherwise every slot carries the idle value 0xFF, and flag and CRC work is left to a downstream framer. In transparent mode the frame counters freeze and bytes go out as they arrive, with no alignment to frames. When the store runs dry, the byte most recently written is sent again. The host requests the mode with a control pin, but the block enters it only while the two frame counters are equal. Either order of bits on the serial line can be selected.

On the write stream a byte moves on a cycle where `wr_valid_i` and `wr_ready_o` are both high. `wr_ready_o` drops when the store is full or an initialisation is under way. The host may keep `wr_valid_i` high while ready is low. On such a cycle the byte is dropped and `overflow_o` reports it. The line side has no back-pressure: every slot strobe is served in the cycle it arrives.

Top module: `bchan_tx_fifo`

## Requirements
- R1: Holding `rst_i` high for at least 4 consecutive cycles initialises the block. Both pointers read 0x1FFF, both frame counters read 0x1F, transparent mode is off and `ser_o` is 1.
- R2: A `rst_i` pulse of fewer than 4 cycles changes no pointer or counter.
- R3: A one-cycle `soft_rst_i` performs the same initialisation as R1 on the next edge.
- R4: A byte is stored when `wr_valid_i` and `wr_ready_o` are both high. The write pointer then increments modulo 2^13, so 0x1FFF is followed by 0x0000.
- R5: The store holds at most 511 bytes. At that occupancy `wr_ready_o` is 0. A write attempt raises `overflow_o` in the same cycle, and the byte is dropped without moving the write pointer.
- R6: In framed mode an accepted byte with `wr_last_i`=1 increments the write frame counter. A slot taken while the two counters are equal returns 0xFF with `slot_idle_o`=1 and leaves the read pointer unchanged.
- R7: In framed mode, while the counters differ, a slot returns the byte at the read pointer with `slot_idle_o`=0 and increments the read pointer. If that byte carried the last-of-frame mark, the read frame counter also increments.
- R8: `trans_req_i`=1 sets `trans_o` on the next edge only while the counters are equal and neither counter is moving. Otherwise the request waits. Dropping `trans_req_i` clears `trans_o` on the next edge.
- R9: While `trans_o`=1 both frame counters hold. Each slot takes the next stored byte with `slot_idle_o`=0, whatever its last-of-frame mark.
- R10: While `trans_o`=1 and the store is empty, a slot repeats the most recently accepted byte with `slot_idle_o`=1. If no byte has been accepted since initialisation, it returns 0xFF.
- R11: A slot loads the serializer. The first bit appears on `ser_o` after that edge, and each `bit_en_i` cycle advances one bit. With `msb_first_i`=0 bit 0 leads; with 1, bit 7 leads. The order is captured at load.
- R12: `slot_byte_o` and `slot_idle_o` change on the edge that takes a slot and then hold until the next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Hardware reset, active high, qualified by length |
| soft_rst_i | input | 1 | Software initialisation strobe |
| trans_req_i | input | 1 | Transparent mode request |
| msb_first_i | input | 1 | Serial order select, 1 sends bit 7 first |
| wr_valid_i | input | 1 | Write stream valid |
| wr_ready_o | output | 1 | Write stream ready |
| wr_data_i | input | 8 | Write stream byte |
| wr_last_i | input | 1 | Marks the byte that ends a frame |
| overflow_o | output | 1 | Write attempted while full |
| slot_i | input | 1 | Line requests one byte |
| bit_en_i | input | 1 | Line bit-clock enable |
| ser_o | output | 1 | Serial data |
| slot_byte_o | output | 8 | Byte of the latest slot |
| slot_idle_o | output | 1 | Latest slot carried no fresh byte |
| trans_o | output | 1 | Transparent mode active |
| z1_o | output | 13 | Write pointer |
| z2_o | output | 13 | Read pointer |
| f1_o | output | 5 | Write frame counter |
| f2_o | output | 5 | Read frame counter |

## Verification
The properties assume that every input is synchronous to the clock. While `rst_i` is high, or in the cycle of a soft reset, the pointers may jump, so the properties do not hold there. They are disabled during `rst_i` and exclude cycles with `soft_rst_i` in their antecedents. The bench changes every input on the falling edge. It starts with a reset long enough to qualify, and it raises `soft_rst_i` for exactly one cycle. This keeps the sequences the properties rely on well defined.

// File: rtl/bchan_tx_pkg.sv
package bchan_tx_pkg;
  typedef struct packed {
    logic       last;
    logic [7:0] data;
  } fifo_word_t;

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction
endpackage

// File: rtl/bchan_rst_qual.sv
module bchan_rst_qual #(
  parameter int MIN_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic soft_rst_i,
  output logic init_o
);
  localparam int HW = (MIN_CYC > 1) ? MIN_CYC - 1 : 1;
  logic [HW-1:0] hist_q;

  generate
    if (HW == 1) begin : g_one
      always_ff @(posedge clk_i) hist_q <= rst_i;
    end else begin : g_shift
      always_ff @(posedge clk_i) hist_q <= {hist_q[HW-2:0], rst_i};
    end
  endgenerate

  // a hardware reset counts only on its MIN_CYC-th consecutive cycle
  assign init_o = soft_rst_i | (rst_i & (&hist_q));
endmodule

// File: rtl/bchan_store.sv
module bchan_store
  import bchan_tx_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic       clk_i,
  input  logic       we_i,
  input  logic [AW-1:0] waddr_i,
  input  fifo_word_t wdata_i,
  input  logic [AW-1:0] raddr_i,
  output fifo_word_t rdata_o
);
  localparam int DEPTH = 1 << AW;
  fifo_word_t mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/bchan_ser.sv
module bchan_ser
  import bchan_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       init_i,
  input  logic       load_i,
  input  logic [7:0] data_i,
  input  logic       msb_first_i,
  input  logic       bit_en_i,
  output logic       ser_o
);
  logic [7:0] sh_q;

  always_ff @(posedge clk_i) begin
    if (init_i)        sh_q <= 8'hFF;
    else if (load_i)   sh_q <= msb_first_i ? rev8(data_i) : data_i;
    else if (bit_en_i) sh_q <= {1'b1, sh_q[7:1]};
  end

  assign ser_o = sh_q[0];
endmodule

// File: rtl/bchan_tx_fifo.sv
module bchan_tx_fifo
  import bchan_tx_pkg::*;
#(
  parameter int PTR_W   = 13,
  parameter int CNT_W   = 5,
  parameter int MEM_AW  = 9,
  parameter int RST_MIN = 4
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             soft_rst_i,
  input  logic             trans_req_i,
  input  logic             msb_first_i,
  input  logic             wr_valid_i,
  output logic             wr_ready_o,
  input  logic [7:0]       wr_data_i,
  input  logic             wr_last_i,
  output logic             overflow_o,
  input  logic             slot_i,
  input  logic             bit_en_i,
  output logic             ser_o,
  output logic [7:0]       slot_byte_o,
  output logic             slot_idle_o,
  output logic             trans_o,
  output logic [PTR_W-1:0] z1_o,
  output logic [PTR_W-1:0] z2_o,
  output logic [CNT_W-1:0] f1_o,
  output logic [CNT_W-1:0] f2_o
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam logic [PTR_W-1:0] FULL_OCC = PTR_W'(DEPTH - 1);

  logic             init;
  logic [PTR_W-1:0] z1_q, z2_q, occ;
  logic [CNT_W-1:0] f1_q, f2_q;
  logic             trans_q, trans_n;
  logic [7:0]       last_wr_q, send_byte, slot_byte_q;
  logic             slot_idle_q, send_idle, pop, do_pop;
  logic             full, empty, wr_fire, f1_inc, f2_inc, load;
  fifo_word_t       wword, rword;

  bchan_rst_qual #(.MIN_CYC(RST_MIN)) u_rstq (
    .clk_i(clk_i), .rst_i(rst_i), .soft_rst_i(soft_rst_i), .init_o(init)
  );

  assign occ        = z1_q - z2_q;
  assign full       = (occ == FULL_OCC);
  assign empty      = (z1_q == z2_q);
  assign wr_ready_o = !full && !init;
  assign wr_fire    = wr_valid_i && wr_ready_o;
  assign overflow_o = wr_valid_i && full && !init;
  assign wword      = '{last: wr_last_i, data: wr_data_i};

  bchan_store #(.AW(MEM_AW)) u_store (
    .clk_i(clk_i), .we_i(wr_fire), .waddr_i(z1_q[MEM_AW-1:0]), .wdata_i(wword),
    .raddr_i(z2_q[MEM_AW-1:0]), .rdata_o(rword)
  );

  // choose what the current slot carries
  always_comb begin
    pop       = 1'b0;
    send_byte = 8'hFF;
    send_idle = 1'b1;
    if (trans_q) begin
      if (!empty) begin
        pop = 1'b1; send_byte = rword.data; send_idle = 1'b0;
      end else begin
        send_byte = last_wr_q;
      end
    end else if (f1_q != f2_q) begin
      pop = 1'b1; send_byte = rword.data; send_idle = 1'b0;
    end
  end

  assign load    = slot_i && !init;
  assign do_pop  = load && pop;
  assign f1_inc  = wr_fire && wr_last_i && !trans_q;
  assign f2_inc  = do_pop && rword.last && !trans_q;
  assign trans_n = trans_req_i && (trans_q || ((f1_q == f2_q) && !f1_inc && !f2_inc));

  always_ff @(posedge clk_i) begin
    if (init) begin
      z1_q        <= '1;
      z2_q        <= '1;
      f1_q        <= '1;
      f2_q        <= '1;
      trans_q     <= 1'b0;
      last_wr_q   <= 8'hFF;
      slot_byte_q <= 8'hFF;
      slot_idle_q <= 1'b1;
    end else begin
      if (wr_fire) begin
        z1_q      <= z1_q + 1'b1;
        last_wr_q <= wr_data_i;
      end
      if (do_pop) z2_q <= z2_q + 1'b1;
      if (f1_inc) f1_q <= f1_q + 1'b1;
      if (f2_inc) f2_q <= f2_q + 1'b1;
      trans_q <= trans_n;
      if (load) begin
        slot_byte_q <= send_byte;
        slot_idle_q <= send_idle;
      end
    end
  end

  bchan_ser u_ser (
    .clk_i(clk_i), .init_i(init), .load_i(load), .data_i(send_byte),
    .msb_first_i(msb_first_i), .bit_en_i(bit_en_i), .ser_o(ser_o)
  );

  assign slot_byte_o = slot_byte_q;
  assign slot_idle_o = slot_idle_q;
  assign trans_o     = trans_q;
  assign z1_o        = z1_q;
  assign z2_o        = z2_q;
  assign f1_o        = f1_q;
  assign f2_o        = f2_q;
endmodule

// File: rtl/bchan_tx_fifo_chk.sv
module bchan_tx_fifo_chk #(
  parameter int PTR_W = 13,
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             soft_rst_i,
  input logic             wr_valid_i,
  input logic             wr_ready_o,
  input logic             slot_i,
  input logic             slot_idle_o,
  input logic [7:0]       slot_byte_o,
  input logic             trans_o,
  input logic [PTR_W-1:0] z1_o,
  input logic [PTR_W-1:0] z2_o,
  input logic [CNT_W-1:0] f1_o,
  input logic [CNT_W-1:0] f2_o
);
  p_soft_init_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    soft_rst_i |=> (z1_o == '1) && (z2_o == '1) && (f1_o == '1) && (f2_o == '1) && !trans_o);

  p_z1_step_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_valid_i && wr_ready_o && !soft_rst_i) |=> z1_o == PTR_W'($past(z1_o) + 1'b1));

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_valid_i && !wr_ready_o && !soft_rst_i) |=> $stable(z1_o));

  p_idle_fill_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (slot_i && !trans_o && (f1_o == f2_o) && !soft_rst_i) |=>
      slot_idle_o && (slot_byte_o == 8'hFF) && $stable(z2_o));

  p_enter_equal_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(trans_o) |-> (f1_o == f2_o));

  p_frozen_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (trans_o && !soft_rst_i) |=> $stable(f1_o) && $stable(f2_o));

  p_empty_repeat_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    (slot_i && trans_o && (z1_o == z2_o) && !soft_rst_i) |=> slot_idle_o && $stable(z2_o));
endmodule

bind bchan_tx_fifo bchan_tx_fifo_chk #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .soft_rst_i(soft_rst_i), .wr_valid_i(wr_valid_i),
  .wr_ready_o(wr_ready_o), .slot_i(slot_i), .slot_idle_o(slot_idle_o),
  .slot_byte_o(slot_byte_o), .trans_o(trans_o), .z1_o(z1_o), .z2_o(z2_o),
  .f1_o(f1_o), .f2_o(f2_o)
);

// File: tb/bchan_tx_fifo_bench.sv
module bchan_tx_fifo_bench;
  logic clk = 1'b0;
  logic rst_i = 1'b1, soft_rst_i = 1'b0, trans_req_i = 1'b0, msb_first_i = 1'b0;
  logic wr_valid_i = 1'b0, wr_last_i = 1'b0, slot_i = 1'b0, bit_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic wr_ready_o, overflow_o, ser_o, slot_idle_o, trans_o;
  logic [7:0] slot_byte_o;
  logic [12:0] z1_o, z2_o;
  logic [4:0] f1_o, f2_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic slot_d = 1'b0;
  logic [8:0] exp_q[$];

  always #2 clk = ~clk;

  bchan_tx_fifo u_bchan_tx_fifo (
    .clk_i(clk), .rst_i(rst_i), .soft_rst_i(soft_rst_i), .trans_req_i(trans_req_i),
    .msb_first_i(msb_first_i), .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
    .wr_data_i(wr_data_i), .wr_last_i(wr_last_i), .overflow_o(overflow_o),
    .slot_i(slot_i), .bit_en_i(bit_en_i), .ser_o(ser_o), .slot_byte_o(slot_byte_o),
    .slot_idle_o(slot_idle_o), .trans_o(trans_o), .z1_o(z1_o), .z2_o(z2_o),
    .f1_o(f1_o), .f2_o(f2_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: one scoreboard entry per slot taken (R12 timing)
  always @(posedge clk) slot_d <= slot_i;
  always @(negedge clk) begin
    if (slot_d) begin
      if (exp_q.size() == 0) chk(1'b0, "R12 unexpected slot", 0, 1);
      else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk({slot_idle_o, slot_byte_o} == e, "R6 R7 R9 R10 R12 slot stream",
            {slot_idle_o, slot_byte_o}, e);
      end
    end
  end

  task automatic wr(input logic [7:0] b, input bit last);
    @(negedge clk); wr_valid_i = 1'b1; wr_data_i = b; wr_last_i = last;
    @(negedge clk); wr_valid_i = 1'b0; wr_last_i = 1'b0;
  endtask

  task automatic do_slot(input logic [7:0] b, input bit idle, input bit msb, input bit ser);
    @(negedge clk); msb_first_i = msb; slot_i = 1'b1; exp_q.push_back({idle, b});
    @(negedge clk); slot_i = 1'b0;
    if (ser) begin
      for (int i = 0; i < 8; i++) begin
        chk(ser_o == (msb ? b[7-i] : b[i]), "R11 serial bit", ser_o, msb ? b[7-i] : b[i]);
        @(negedge clk); bit_en_i = 1'b1;
        @(negedge clk); bit_en_i = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_i = 1'b0;
    @(negedge clk);
    chk(z1_o == 13'h1FFF && z2_o == 13'h1FFF, "R1 pointers", z1_o, 13'h1FFF);
    chk(f1_o == 5'h1F && f2_o == 5'h1F, "R1 counters", f1_o, 5'h1F);
    chk(!trans_o && ser_o, "R1 mode/serial", {trans_o, ser_o}, 1);

    do_slot(8'hFF, 1'b1, 1'b0, 1'b0);            // R6 idle with no frame
    wr(8'hA1, 1'b0); wr(8'hB2, 1'b0); wr(8'hC3, 1'b1);
    chk(z1_o == 13'h0002, "R4 write pointer wrap", z1_o, 2);
    chk(f1_o == 5'h00, "R6 frame count", f1_o, 0);
    do_slot(8'hA1, 1'b0, 1'b0, 1'b1);
    do_slot(8'hB2, 1'b0, 1'b1, 1'b1);
    do_slot(8'hC3, 1'b0, 1'b0, 1'b0);
    chk(z2_o == 13'h0002 && f2_o == 5'h00, "R7 read side", {f2_o, z2_o}, 2);
    do_slot(8'hFF, 1'b1, 1'b0, 1'b0);

    wr(8'hD4, 1'b0); wr(8'hE5, 1'b0);
    do_slot(8'hFF, 1'b1, 1'b0, 1'b0);            // R6 unfinished frame held
    @(negedge clk); trans_req_i = 1'b1;
    @(negedge clk);
    chk(trans_o == 1'b1, "R8 enter", trans_o, 1);
    do_slot(8'hD4, 1'b0, 1'b0, 1'b0);
    do_slot(8'hE5, 1'b0, 1'b0, 1'b0);
    do_slot(8'hE5, 1'b1, 1'b1, 1'b1);            // R10 repeat
    wr(8'h55, 1'b1);
    chk(f1_o == 5'h00 && f2_o == 5'h00, "R9 counters frozen", f1_o, 0);
    do_slot(8'h55, 1'b0, 1'b0, 1'b0);
    @(negedge clk); trans_req_i = 1'b0;
    @(negedge clk);
    chk(trans_o == 1'b0, "R8 leave", trans_o, 0);

    wr(8'h66, 1'b1);
    @(negedge clk); trans_req_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(trans_o == 1'b0, "R8 held off", trans_o, 0);
    do_slot(8'h66, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk(trans_o == 1'b1 && f2_o == 5'h01, "R8 entry after frame sent", {trans_o, f2_o}, 6'h21);
    trans_req_i = 1'b0;
    @(negedge clk);

    rst_i = 1'b1; repeat (3) @(negedge clk); rst_i = 1'b0;
    @(negedge clk);
    chk(z1_o == 13'h0006 && f1_o == 5'h01, "R2 short reset ignored", z1_o, 6);

    soft_rst_i = 1'b1; @(negedge clk); soft_rst_i = 1'b0;
    chk(z1_o == 13'h1FFF && z2_o == 13'h1FFF && f1_o == 5'h1F && f2_o == 5'h1F,
        "R3 soft init", z1_o, 13'h1FFF);
    trans_req_i = 1'b1; @(negedge clk);
    do_slot(8'hFF, 1'b1, 1'b0, 1'b0);            // R10 nothing written since init
    trans_req_i = 1'b0; @(negedge clk);

    wr(8'h01, 1'b0);
    chk(z1_o == 13'h0000, "R4 wrap from all ones", z1_o, 0);
    for (int i = 0; i < 510; i++) wr(i[7:0], 1'b0);
    chk(z1_o == 13'h01FE && wr_ready_o == 1'b0, "R5 full", {wr_ready_o, z1_o}, 13'h01FE);
    @(negedge clk); wr_valid_i = 1'b1; wr_data_i = 8'h77;
    #1 chk(overflow_o == 1'b1, "R5 overflow flag", overflow_o, 1);
    @(negedge clk); wr_valid_i = 1'b0;
    chk(z1_o == 13'h01FE, "R5 write dropped", z1_o, 13'h01FE);

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R12 all slots seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule